// File: doc/BRIEF.md
# Double-Buffered Register Commit Unit

This block holds a bank of 32-bit control registers behind a simple memory-mapped write/read port. Software writes always land in a shadow copy. A second, active copy drives the downstream display logic, and it changes only at the rising edge of the vertical-blank input. This keeps the display from ever seeing a half-updated set of settings.

Register index 0 (byte offset 0) is the buffer-control register. Its bit 0 turns automatic copying off. Its bit 1 requests a single copy at the next blank. When bit 0 is clear, the whole shadow bank is copied at every blank rising edge. When bit 0 is set, a copy happens only while a request is pending. The request bit reads back as 1 until the copy has taken place and then clears itself, so software can poll it before it starts the next round of updates. A commit is one write that sets both bits (value 3).

Register index 1 (byte offset 4) is the module-control register. In its active copy, bit 0 enables the module, bit 1 is the start control, and bits 8 and up hold one enable per layer. These fields are decoded onto output pins.

Top module: `shadow_commit_regs`

## Requirements
- R1: After reset every readback value, the whole active bank and all decoded outputs are 0.
- R2: A write to register index k (1 to NUM_REGS-1, at byte address 4k, address bits 1:0 ignored) is visible in the readback on the next cycle, and the active copy of k does not change before a blank edge.
- R3: With buffer-control bit 0 clear, each rising edge of vblank copies the whole shadow bank to the active bank at that clock edge.
- R4: With buffer-control bit 0 set and no pending request, a vblank rising edge leaves the active bank unchanged.
- R5: Writing buffer-control bit 1 as 1 makes it read back as 1. The next vblank rising edge copies the shadow bank and clears bit 1.
- R6: Holding vblank high copies only once. Shadow writes made while vblank stays high do not reach the active bank until the next rising edge.
- R7: A request written in the same cycle as a blank rising edge is held over to the following edge. A shadow write made in the same cycle as a copy is not part of that copy.
- R8: Writes to an index at or beyond NUM_REGS (for example byte 0x5800) change no register, and reads there return 0.
- R9: mod_enable follows bit 0, mod_start follows bit 1, and layer_enable[i] follows bit 8+i of the active module-control register.
- R10: Writing buffer-control bit 1 as 0 does not cancel a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address, stride 4 |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational readback of the addressed register |
| vblank | input | 1 | Vertical-blank level from the timing logic |
| act_regs | output | NUM_REGS*DATA_W | Active bank, register k at bits k*DATA_W upward |
| mod_enable | output | 1 | Module enable from the active module-control register |
| mod_start | output | 1 | Start control from the active module-control register |
| layer_enable | output | NUM_LAYERS | Per-layer enables from the active module-control register |

## Verification
The bench targets the cycle in which a blank edge coincides with a write. A design that copied the post-write shadow, or that dropped a request written on the edge, would show the wrong active value one blank early or never. It holds vblank high across several writes, which exposes a level-triggered copy, and it writes the request bit as 0 while a request is pending, which catches a design that lets software cancel its own commit. Out-of-range and misaligned addresses are also covered: an aliasing decoder would corrupt a live register, and a wrong readback mux would return stale data.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
    // Buffer-control register fields
    localparam int unsigned CTRL_IDX       = 0;
    localparam int unsigned AUTOLOAD_OFF_B = 0;
    localparam int unsigned LOAD_REQ_B     = 1;
    // Module-control register fields
    localparam int unsigned MODCTL_IDX     = 1;
    localparam int unsigned MOD_EN_B       = 0;
    localparam int unsigned MOD_START_B    = 1;
    localparam int unsigned LAYER_EN_LSB   = 8;

    typedef struct packed {
        logic autoload_off;
        logic load_req;
    } sc_ctrl_t;
endpackage

// File: rtl/sc_edge_detect.sv
`timescale 1ns/1ps
module sc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    typedef struct packed {
        logic level;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = level & ~st_q.level;

    // R6: a level held high yields one pulse only
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sc_ctrl.sv
`timescale 1ns/1ps
module sc_ctrl
    import sc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  logic     wr_autoload_off,
    input  logic     wr_load,
    input  logic     blank_rise,
    output logic     copy,
    output sc_ctrl_t ctrl
);
    sc_ctrl_t ctrl_d, ctrl_q;
    logic     copy_d;

    always_comb begin
        ctrl_d = ctrl_q;
        copy_d = blank_rise & (~ctrl_q.autoload_off | ctrl_q.load_req);
        // a request set in the copy cycle survives to the next blank
        ctrl_d.load_req = (ctrl_q.load_req & ~copy_d) | (ctrl_wr & wr_load);
        if (ctrl_wr) ctrl_d.autoload_off = wr_autoload_off;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign copy = copy_d;
    assign ctrl = ctrl_q;

    // R10: pending request survives until a blank edge
    p_pending_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.load_req && !blank_rise |=> ctrl_q.load_req);
    // R5: blank edge clears the request unless re-armed
    p_load_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.load_req && blank_rise && !(ctrl_wr && wr_load) |=> !ctrl_q.load_req);
    // R7: request written on the edge is held over
    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && wr_load |=> ctrl_q.load_req);
endmodule

// File: rtl/sc_bank.sv
`timescale 1ns/1ps
module sc_bank #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic                               copy,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    shadow,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    active
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] shadow;
        logic [NUM_REGS-1:0][DATA_W-1:0] active;
    } bank_st_t;

    bank_st_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (copy)  bank_d.active = bank_q.shadow;
        if (wr_en) bank_d.shadow[wr_idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign shadow = bank_q.shadow;
    assign active = bank_q.active;

    // R2: write lands in the shadow copy
    p_shadow_takes_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bank_q.shadow[$past(wr_idx)] == $past(wdata));
    // R4: active copy frozen without a copy strobe
    p_active_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !copy |=> $stable(bank_q.active));
    // R3: copy takes the pre-write shadow
    p_copy_takes_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        copy |=> bank_q.active == $past(bank_q.shadow));
endmodule

// File: rtl/shadow_commit_regs.sv
`timescale 1ns/1ps
module shadow_commit_regs
    import sc_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 15,
    parameter int unsigned NUM_LAYERS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    input  logic                         vblank,
    output logic [NUM_REGS*DATA_W-1:0]   act_regs,
    output logic                         mod_enable,
    output logic                         mod_start,
    output logic [NUM_LAYERS-1:0]        layer_enable
);
    localparam int unsigned IDX_W      = $clog2(NUM_REGS);
    localparam int unsigned FULL_IDX_W = ADDR_W - 2;
    localparam logic [FULL_IDX_W-1:0] REG_LIMIT = FULL_IDX_W'(NUM_REGS);
    localparam logic [FULL_IDX_W-1:0] CTRL_SEL  = FULL_IDX_W'(CTRL_IDX);

    logic [FULL_IDX_W-1:0]             idx;
    logic                              in_range, is_ctrl;
    logic                              blank_rise, copy;
    sc_ctrl_t                          ctrl;
    logic [NUM_REGS-1:0][DATA_W-1:0]   shadow, active;

    assign idx      = addr[ADDR_W-1:2];
    assign in_range = idx < REG_LIMIT;
    assign is_ctrl  = idx == CTRL_SEL;

    sc_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (vblank),
        .rise  (blank_rise)
    );

    sc_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctrl_wr         (wr_en & is_ctrl),
        .wr_autoload_off (wdata[AUTOLOAD_OFF_B]),
        .wr_load         (wdata[LOAD_REQ_B]),
        .blank_rise      (blank_rise),
        .copy            (copy),
        .ctrl            (ctrl)
    );

    sc_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en & in_range & ~is_ctrl),
        .wr_idx (idx[IDX_W-1:0]),
        .wdata  (wdata),
        .copy   (copy),
        .shadow (shadow),
        .active (active)
    );

    always_comb begin
        rdata = '0;
        if (is_ctrl) begin
            rdata[AUTOLOAD_OFF_B] = ctrl.autoload_off;
            rdata[LOAD_REQ_B]     = ctrl.load_req;
        end else if (in_range) begin
            rdata = shadow[idx[IDX_W-1:0]];
        end
    end

    assign act_regs   = active;
    assign mod_enable = active[MODCTL_IDX][MOD_EN_B];
    assign mod_start  = active[MODCTL_IDX][MOD_START_B];

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
        assign layer_enable[g] = active[MODCTL_IDX][LAYER_EN_LSB+g];
    end

    // R4: with autoload off and nothing pending, a blank edge does not move the active bank
    p_no_copy_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blank_rise && ctrl.autoload_off && !ctrl.load_req |=> $stable(act_regs));
    // R3: with autoload on, a blank edge copies the shadow bank
    p_autoload_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blank_rise && !ctrl.autoload_off |=> act_regs == $past(shadow));
endmodule

// File: tb/test_shadow_commit_regs.sv
`timescale 1ns/1ps
module test_shadow_commit_regs;
    localparam int NR = 8;
    localparam int NL = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [14:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              vblank = 1'b0;
    logic [NR*32-1:0]  act_regs;
    logic              mod_enable, mod_start;
    logic [NL-1:0]     layer_enable;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_sh [NR];
    logic [31:0] m_ac [NR];
    logic        m_aoff, m_lreq, m_vb;

    always #2.5 clk = ~clk;

    shadow_commit_regs i_shadow_commit_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .vblank(vblank), .act_regs(act_regs),
        .mod_enable(mod_enable), .mod_start(mod_start), .layer_enable(layer_enable)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int k);
        if (k == 0) return {30'b0, m_lreq, m_aoff};
        if (k < NR) return m_sh[k];
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_decode();
        return {26'b0, m_ac[1][0], m_ac[1][1], m_ac[1][11:8]};
    endfunction

    // one clock: drive inputs, advance the model, sample at the following negedge
    task automatic step(input logic we, input logic [14:0] a, input logic [31:0] d, input logic vb);
        int  k;
        logic rise, cp;
        wr_en = we; addr = a; wdata = d; vblank = vb;
        k    = int'(a[14:2]);
        rise = vb & ~m_vb;
        cp   = rise & (~m_aoff | m_lreq);
        if (cp) for (int i = 0; i < NR; i++) m_ac[i] = m_sh[i];
        if (cp) m_lreq = 1'b0;
        if (we && k == 0) begin
            m_aoff = d[0];
            if (d[1]) m_lreq = 1'b1;
        end
        if (we && k > 0 && k < NR) m_sh[k] = d;
        m_vb = vb;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic compare_all(input string tag);
        for (int k = 0; k < NR; k++) begin
            addr = 15'(k * 4);
            #0.2;
            chk(tag, rdata, exp_read(k));
            chk(tag, act_regs[k*32 +: 32], m_ac[k]);
        end
        chk({tag, "/R9"}, {26'b0, mod_enable, mod_start, layer_enable}, exp_decode());
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        for (int i = 0; i < NR; i++) begin m_sh[i] = '0; m_ac[i] = '0; end
        m_aoff = 1'b0; m_lreq = 1'b0; m_vb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1 reset");

        // R2: shadow write visible, active untouched
        step(1'b1, 15'h0008, 32'hA5A5_0001, 1'b0);
        compare_all("R2 shadow write");
        // R2: low address bits ignored
        step(1'b1, 15'h000B, 32'hA5A5_0002, 1'b0);
        compare_all("R2 low bits");

        // R3: autoload on, blank edge copies
        step(1'b0, 15'h0, 32'h0, 1'b1);
        compare_all("R3 autoload copy");
        // R6: held high, no second copy
        step(1'b1, 15'h0008, 32'h1234_5678, 1'b1);
        step(1'b0, 15'h0, 32'h0, 1'b1);
        compare_all("R6 level held");
        step(1'b0, 15'h0, 32'h0, 1'b0);
        step(1'b0, 15'h0, 32'h0, 1'b1);
        compare_all("R3 second edge");

        // R4: autoload off, no request
        step(1'b1, 15'h0000, 32'h1, 1'b0);
        step(1'b1, 15'h000C, 32'hCAFE_0003, 1'b0);
        step(1'b0, 15'h0, 32'h0, 1'b1);
        compare_all("R4 no copy");

        // R5 / R10: commit, then try to cancel with bit1 = 0
        step(1'b1, 15'h0000, 32'h3, 1'b0);
        compare_all("R5 pending");
        step(1'b1, 15'h0000, 32'h1, 1'b0);
        compare_all("R10 no cancel");
        step(1'b0, 15'h0, 32'h0, 1'b1);
        compare_all("R5 commit done");

        // R7: request on the edge is held over
        step(1'b0, 15'h0, 32'h0, 1'b0);
        step(1'b1, 15'h0010, 32'hBEEF_0004, 1'b0);
        step(1'b1, 15'h0000, 32'h3, 1'b1);
        compare_all("R7 request on edge");
        step(1'b0, 15'h0, 32'h0, 1'b0);
        // R7: shadow write in the copy cycle is excluded
        step(1'b1, 15'h0014, 32'hD00D_0005, 1'b1);
        compare_all("R7 write during copy");

        // R8: out-of-range writes and reads
        step(1'b1, 15'h5800, 32'hFFFF_FFFF, 1'b0);
        compare_all("R8 out of range");
        addr = 15'h5800; #0.2;
        chk("R8 read out of range", rdata, 32'h0);
        addr = 15'h0020; #0.2;
        chk("R8 read past end", rdata, 32'h0);

        // R9: module-control decode after commit
        step(1'b1, 15'h0004, 32'h0000_0A03, 1'b0);
        step(1'b1, 15'h0000, 32'h3, 1'b0);
        step(1'b0, 15'h0, 32'h0, 1'b1);
        compare_all("R9 decode");
        step(1'b0, 15'h0, 32'h0, 1'b0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int          ri;
            logic [31:0] rd;
            logic        rwe, rvb;
            ri  = int'($urandom_range(0, NR + 2));
            rd  = $urandom();
            rwe = ($urandom_range(0, 3) != 0);
            rvb = ($urandom_range(0, 2) == 0);
            if (ri == 0) rd = {30'b0, rd[1:0]};
            step(rwe, 15'(ri * 4 + int'($urandom_range(0, 3))), rd, rvb);
            compare_all("R3/R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule